// File: doc/BRIEF.md
# Processor Exception State Unit

This unit holds the exception-related machine state of a simple 32-bit processor: the saved program counter of the faulting instruction, a cause word and a status word. When the pipeline raises an exception request with a 4-bit reason code and the PC of the instruction after the faulting one, the unit records the faulting address and the reason. It also pushes the processor into kernel mode with interrupts off, and on the next cycle it tells the fetch stage to jump to a fixed handler entry. A return strobe pops the mode stack and sends fetch back to the saved address.

Five hardware interrupt lines are latched into pending bits. A pending bit is set even while interrupts are disabled, and it stays set until software acknowledges it. An interrupt-request output combines the pending bits, the per-level mask and the current global enable. Software reads the three registers through a select-addressed port and writes them through the same port. Hardware events in the same cycle always win over a software write.

Top module: `exc_state_unit`

## Requirements
- R1: After a synchronous reset, the status, cause and saved-PC registers read as zero, `redirect_valid` is 0 and `irq_out` is 0.
- R2: Status bits 5:0 form three (kernel/user, enable) pairs, with the enable bit of the current pair at bit 0. An exception request sets bits 5:0 to {old 3:0, 2'b00} on the next cycle and leaves the mask in status bits 15:8 unchanged.
- R3: A return strobe without an exception sets status bits 5:0 to {old 5:4, old 5:2} on the next cycle. On that cycle `redirect_valid` is 1 and `redirect_pc` equals the saved PC.
- R4: Hardware line i sets cause bit 8+i on the cycle after it is seen high, whatever the enable and mask. The bit stays set until a software write to the cause register puts a 1 at that bit position while the line is low.
- R5: An exception request stores its 4-bit code in cause bits 5:2. Software writes never change these bits. Cause bits 15:13 are three software-settable pending bits, and cause bits 31:16, 7:6 and 1:0 read 0.
- R6: An exception request loads the saved-PC register with `exc_pc` minus 4 (modulo 2^32).
- R7: On the cycle after an exception request, `redirect_valid` is 1 and `redirect_pc` is 0x8000_0080. `redirect_valid` is 0 on any cycle that follows neither an exception request nor a return strobe.
- R8: `irq_out` is 1 exactly when status bit 0 is 1 and some bit k in 15:8 is set in both the status and the cause register.
- R9: The select port uses 0 for status, 1 for cause, 2 for saved PC and 3 for a constant zero. The read data is combinational. Status writes take only bits 15:8 and 5:0, and its other bits read 0. The saved PC takes all 32 bits.
- R10: An exception request takes priority over a return strobe in the same cycle. Either event cancels a software write issued in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exc_req | input | 1 | Exception request strobe |
| exc_code | input | 4 | Reason code for the exception |
| exc_pc | input | 32 | PC of the instruction after the faulting one |
| hw_irq | input | 5 | Hardware interrupt lines |
| eret | input | 1 | Return-from-exception strobe |
| csr_wr | input | 1 | Software write enable |
| csr_sel | input | 2 | Register select for reads and writes |
| csr_wdata | input | 32 | Software write data |
| csr_rdata | output | 32 | Read data for the selected register |
| redirect_pc | output | 32 | Target for the fetch stage |
| redirect_valid | output | 1 | Fetch must jump to `redirect_pc` this cycle |
| irq_out | output | 1 | Interrupt request to the pipeline |

## Verification
Every register update (mode stack, pending bits, code, saved PC) and both redirect outputs appear one clock after the strobe or line that causes them. `csr_rdata` and `irq_out` are combinational views of those registers. The bench drives each stimulus on a falling edge and holds it across exactly one rising edge. It then checks the registered results at the next falling edge, and reads the register port a nanosecond after changing the select. Persistence cases, such as a pending bit surviving idle cycles or `redirect_valid` dropping after one cycle, are checked on later falling edges, counted one per clock.

// File: rtl/exc_pkg.sv
package exc_pkg;

    localparam int XLEN       = 32;
    localparam int NHW        = 5;
    localparam int NSW        = 3;
    localparam int NLVL       = NHW + NSW;
    localparam int CODE_W     = 4;
    localparam int PEND_LSB   = 8;
    localparam int CODE_LSB   = 2;
    localparam int INSN_BYTES = 4;
    localparam logic [XLEN-1:0] HANDLER_ADDR = 32'h8000_0080;

    typedef enum logic [1:0] {
        SEL_STATUS = 2'd0,
        SEL_CAUSE  = 2'd1,
        SEL_EPC    = 2'd2,
        SEL_ZERO   = 2'd3
    } csr_sel_e;

    // one (kernel/user, enable) pair; enable sits in the low bit
    typedef struct packed {
        logic ku;
        logic ie;
    } mode_pair_t;

    typedef struct packed {
        mode_pair_t oldest;
        mode_pair_t prior;
        mode_pair_t cur;
    } mode_stack_t;

    function automatic mode_stack_t stack_push(mode_stack_t s);
        mode_stack_t r;
        r.oldest = s.prior;
        r.prior  = s.cur;
        r.cur    = '0;
        return r;
    endfunction

    function automatic mode_stack_t stack_pop(mode_stack_t s);
        mode_stack_t r;
        r.oldest = s.oldest;
        r.prior  = s.oldest;
        r.cur    = s.prior;
        return r;
    endfunction

    function automatic logic [XLEN-1:0] pack_status(logic [NLVL-1:0] mask, mode_stack_t s);
        logic [XLEN-1:0] w;
        w = '0;
        w[PEND_LSB +: NLVL] = mask;
        w[5:0] = s;
        return w;
    endfunction

    function automatic logic [XLEN-1:0] pack_cause(logic [NLVL-1:0] pend, logic [CODE_W-1:0] code);
        logic [XLEN-1:0] w;
        w = '0;
        w[PEND_LSB +: NLVL] = pend;
        w[CODE_LSB +: CODE_W] = code;
        return w;
    endfunction

endpackage

// File: rtl/exc_mode_stack.sv
module exc_mode_stack
    import exc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            exc_take,
    input  logic            ret_take,
    input  logic            wr_en,
    input  logic [XLEN-1:0] wr_data,
    output logic [NLVL-1:0] mask,
    output mode_stack_t     stk
);

    always_ff @(posedge clk) begin
        if (rst) begin
            mask <= '0;
            stk  <= '0;
        end else if (exc_take) begin
            stk <= stack_push(stk);
        end else if (ret_take) begin
            stk <= stack_pop(stk);
        end else if (wr_en) begin
            mask <= wr_data[PEND_LSB +: NLVL];
            stk  <= mode_stack_t'(wr_data[5:0]);
        end
    end

    AST_PUSH_KERNEL: assert property (@(posedge clk) disable iff (rst)
        exc_take |=> (stk.cur == 2'b00) && (stk.oldest == $past(stk.prior))
                     && (mask == $past(mask)));  // R2

    AST_POP_RESTORE: assert property (@(posedge clk) disable iff (rst)
        (ret_take && !exc_take) |=> (stk.cur == $past(stk.prior))
                                    && (stk.oldest == $past(stk.oldest)));  // R3

endmodule

// File: rtl/exc_cause_reg.sv
module exc_cause_reg
    import exc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              exc_take,
    input  logic [CODE_W-1:0] exc_code,
    input  logic [NHW-1:0]    hw_irq,
    input  logic              wr_en,
    input  logic [XLEN-1:0]   wr_data,
    output logic [NLVL-1:0]   pend,
    output logic [CODE_W-1:0] code
);

    logic [NHW-1:0] hw_pend;
    logic [NSW-1:0] sw_pend;
    logic [NHW-1:0] hw_pend_nx;

    always_comb begin
        hw_pend_nx = hw_pend;
        if (wr_en)
            hw_pend_nx = hw_pend_nx & ~wr_data[PEND_LSB +: NHW];
        hw_pend_nx = hw_pend_nx | hw_irq;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hw_pend <= '0;
            sw_pend <= '0;
            code    <= '0;
        end else begin
            hw_pend <= hw_pend_nx;
            if (wr_en)
                sw_pend <= wr_data[PEND_LSB+NHW +: NSW];
            if (exc_take)
                code <= exc_code;
        end
    end

    assign pend = {sw_pend, hw_pend};

    AST_PEND_LATCH: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((hw_pend & $past(hw_irq)) == $past(hw_irq)));  // R4

    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> ((hw_pend & $past(hw_pend)) == $past(hw_pend)));  // R4

    AST_CODE_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        exc_take |=> (code == $past(exc_code)));  // R5

endmodule

// File: rtl/exc_pc_unit.sv
module exc_pc_unit
    import exc_pkg::*;
#(
    parameter logic [XLEN-1:0] HANDLER_PC = HANDLER_ADDR
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            exc_take,
    input  logic            ret_take,
    input  logic [XLEN-1:0] exc_pc,
    input  logic            wr_en,
    input  logic [XLEN-1:0] wr_data,
    output logic [XLEN-1:0] epc,
    output logic [XLEN-1:0] redir_pc,
    output logic            redir_valid
);

    localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

    always_ff @(posedge clk) begin
        if (rst) begin
            epc         <= '0;
            redir_pc    <= '0;
            redir_valid <= 1'b0;
        end else begin
            if (exc_take)
                epc <= exc_pc - STEP;
            else if (wr_en)
                epc <= wr_data;
            redir_valid <= exc_take | ret_take;
            if (exc_take)
                redir_pc <= HANDLER_PC;
            else if (ret_take)
                redir_pc <= epc;
        end
    end

    AST_EPC_BACKUP: assert property (@(posedge clk) disable iff (rst)
        exc_take |=> (epc + STEP == $past(exc_pc)));  // R6

    AST_REDIR_HANDLER: assert property (@(posedge clk) disable iff (rst)
        exc_take |=> (redir_valid && redir_pc == HANDLER_PC));  // R7

    AST_REDIR_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!exc_take && !ret_take) |=> !redir_valid);  // R7

    AST_REDIR_RETURN: assert property (@(posedge clk) disable iff (rst)
        (ret_take && !exc_take) |=> (redir_valid && redir_pc == $past(epc)));  // R3

endmodule

// File: rtl/exc_state_unit.sv
module exc_state_unit
    import exc_pkg::*;
#(
    parameter logic [XLEN-1:0] HANDLER_PC = HANDLER_ADDR
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              exc_req,
    input  logic [CODE_W-1:0] exc_code,
    input  logic [XLEN-1:0]   exc_pc,
    input  logic [NHW-1:0]    hw_irq,
    input  logic              eret,
    input  logic              csr_wr,
    input  logic [1:0]        csr_sel,
    input  logic [XLEN-1:0]   csr_wdata,
    output logic [XLEN-1:0]   csr_rdata,
    output logic [XLEN-1:0]   redirect_pc,
    output logic              redirect_valid,
    output logic              irq_out
);

    logic            ret_take;
    logic            sw_ok;
    logic            wr_status, wr_cause, wr_epc;
    logic [NLVL-1:0] mask;
    mode_stack_t     stk;
    logic [NLVL-1:0] pend;
    logic [CODE_W-1:0] code;
    logic [XLEN-1:0] epc;
    csr_sel_e        sel;

    // exception beats return; either hardware event drops the software write
    assign ret_take  = eret & ~exc_req;
    assign sw_ok     = csr_wr & ~exc_req & ~eret;
    assign sel       = csr_sel_e'(csr_sel);
    assign wr_status = sw_ok && (sel == SEL_STATUS);
    assign wr_cause  = sw_ok && (sel == SEL_CAUSE);
    assign wr_epc    = sw_ok && (sel == SEL_EPC);

    exc_mode_stack u_status (
        .clk      (clk),
        .rst      (rst),
        .exc_take (exc_req),
        .ret_take (ret_take),
        .wr_en    (wr_status),
        .wr_data  (csr_wdata),
        .mask     (mask),
        .stk      (stk)
    );

    exc_cause_reg u_cause (
        .clk      (clk),
        .rst      (rst),
        .exc_take (exc_req),
        .exc_code (exc_code),
        .hw_irq   (hw_irq),
        .wr_en    (wr_cause),
        .wr_data  (csr_wdata),
        .pend     (pend),
        .code     (code)
    );

    exc_pc_unit #(.HANDLER_PC(HANDLER_PC)) u_pc (
        .clk         (clk),
        .rst         (rst),
        .exc_take    (exc_req),
        .ret_take    (ret_take),
        .exc_pc      (exc_pc),
        .wr_en       (wr_epc),
        .wr_data     (csr_wdata),
        .epc         (epc),
        .redir_pc    (redirect_pc),
        .redir_valid (redirect_valid)
    );

    always_comb begin
        unique case (sel)
            SEL_STATUS: csr_rdata = pack_status(mask, stk);
            SEL_CAUSE:  csr_rdata = pack_cause(pend, code);
            SEL_EPC:    csr_rdata = epc;
            default:    csr_rdata = '0;
        endcase
    end

    assign irq_out = stk.cur.ie & (|(mask & pend));

    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
        !stk.cur.ie |-> !irq_out);  // R8

    AST_EXC_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (rst)
        (exc_req && csr_wr && sel == SEL_STATUS) |=> (stk.cur == 2'b00));  // R10

    AST_KERNEL_AFTER_EXC: assert property (@(posedge clk) disable iff (rst)
        exc_req |=> !irq_out);  // R2

endmodule

// File: tb/sim_exc_state_unit.sv
`timescale 1ns/1ps
module sim_exc_state_unit;
    import exc_pkg::*;

    logic        clk = 1'b0;
    logic        rst;
    logic        exc_req;
    logic [3:0]  exc_code;
    logic [31:0] exc_pc;
    logic [4:0]  hw_irq;
    logic        eret;
    logic        csr_wr;
    logic [1:0]  csr_sel;
    logic [31:0] csr_wdata;
    logic [31:0] csr_rdata;
    logic [31:0] redirect_pc;
    logic        redirect_valid;
    logic        irq_out;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    exc_state_unit u0 (
        .clk(clk), .rst(rst), .exc_req(exc_req), .exc_code(exc_code),
        .exc_pc(exc_pc), .hw_irq(hw_irq), .eret(eret), .csr_wr(csr_wr),
        .csr_sel(csr_sel), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
        .redirect_pc(redirect_pc), .redirect_valid(redirect_valid),
        .irq_out(irq_out)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] s, output logic [31:0] v);
        csr_sel = s;
        #1;
        v = csr_rdata;
    endtask

    // one clock with the present inputs, then strobes drop at the falling edge
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        exc_req = 1'b0;
        eret    = 1'b0;
        csr_wr  = 1'b0;
    endtask

    task automatic wr(input logic [1:0] s, input logic [31:0] d);
        csr_sel = s; csr_wdata = d; csr_wr = 1'b1;
        tick();
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        rd(2'd0, v); chk(v, 32'h0, "R1 status after reset");
        rd(2'd1, v); chk(v, 32'h0, "R1 cause after reset");
        rd(2'd2, v); chk(v, 32'h0, "R1 epc after reset");
        chk({31'b0, redirect_valid}, 32'h0, "R1 redirect_valid after reset");
        chk({31'b0, irq_out}, 32'h0, "R1 irq_out after reset");
    endtask

    task automatic t_exception();
        logic [31:0] v;
        wr(2'd0, 32'h0000_FF3D);
        rd(2'd0, v); chk(v, 32'h0000_FF3D, "R9 status write");
        exc_req = 1'b1; exc_code = 4'd12; exc_pc = 32'h0000_1000;
        tick();
        chk({31'b0, redirect_valid}, 32'h1, "R7 redirect_valid on exception");
        chk(redirect_pc, 32'h8000_0080, "R7 handler address");
        rd(2'd0, v); chk(v, 32'h0000_FF34, "R2 stack push");
        rd(2'd1, v); chk(v, 32'h0000_0030, "R5 code overflow");
        rd(2'd2, v); chk(v, 32'h0000_0FFC, "R6 epc = pc-4");
        chk({31'b0, irq_out}, 32'h0, "R2 interrupts off in handler");
        @(negedge clk);
        chk({31'b0, redirect_valid}, 32'h0, "R7 redirect_valid one cycle");
    endtask

    task automatic t_return();
        logic [31:0] v;
        eret = 1'b1;
        tick();
        chk({31'b0, redirect_valid}, 32'h1, "R3 redirect_valid on return");
        chk(redirect_pc, 32'h0000_0FFC, "R3 return to epc");
        rd(2'd0, v); chk(v, 32'h0000_FF3D, "R3 stack pop");
        @(negedge clk);
        chk({31'b0, redirect_valid}, 32'h0, "R7 redirect_valid drops after return");
    endtask

    task automatic t_pending();
        logic [31:0] v;
        wr(2'd0, 32'h0);
        hw_irq = 5'b00100;
        tick();
        hw_irq = 5'b0;
        rd(2'd1, v); chk(v, 32'h0000_0430, "R4 pending set while disabled");
        chk({31'b0, irq_out}, 32'h0, "R8 no irq while disabled");
        repeat (3) @(negedge clk);
        rd(2'd1, v); chk(v, 32'h0000_0430, "R4 pending holds");
        wr(2'd0, 32'h0000_0400);
        chk({31'b0, irq_out}, 32'h0, "R8 masked in but enable off");
        wr(2'd0, 32'h0000_0401);
        chk({31'b0, irq_out}, 32'h1, "R8 enable and mask match");
        wr(2'd0, 32'h0000_0801);
        chk({31'b0, irq_out}, 32'h0, "R8 other level masked");
        wr(2'd0, 32'h0000_0401);
        hw_irq = 5'b00100;
        wr(2'd1, 32'h0000_0400);
        hw_irq = 5'b0;
        rd(2'd1, v); chk(v, 32'h0000_0430, "R4 clear loses to live line");
        wr(2'd1, 32'h0000_0400);
        rd(2'd1, v); chk(v, 32'h0000_0030, "R4 acknowledge clears");
        chk({31'b0, irq_out}, 32'h0, "R8 irq drops after acknowledge");
    endtask

    task automatic t_software();
        logic [31:0] v;
        wr(2'd1, 32'h0000_203C);
        rd(2'd1, v); chk(v, 32'h0000_2030, "R5 code not software writable");
        chk({31'b0, irq_out}, 32'h0, "R8 software level masked");
        wr(2'd0, 32'h0000_2001);
        chk({31'b0, irq_out}, 32'h1, "R8 software level enabled");
        wr(2'd0, 32'hFFFF_FFFF);
        rd(2'd0, v); chk(v, 32'h0000_FF3F, "R9 status writable bits");
        wr(2'd2, 32'h1234_5678);
        rd(2'd2, v); chk(v, 32'h1234_5678, "R9 epc write");
        rd(2'd3, v); chk(v, 32'h0, "R9 select 3 reads zero");
        wr(2'd1, 32'h0);
        rd(2'd1, v); chk(v, 32'h0000_0030, "R5 software pending cleared");
    endtask

    task automatic t_priority();
        logic [31:0] v;
        exc_req = 1'b1; exc_code = 4'd8; exc_pc = 32'h0;
        csr_sel = 2'd0; csr_wdata = 32'h0; csr_wr = 1'b1;
        tick();
        rd(2'd0, v); chk(v, 32'h0000_FF3C, "R10 exception beats status write");
        rd(2'd2, v); chk(v, 32'hFFFF_FFFC, "R6 epc wraps");
        rd(2'd1, v); chk(v, 32'h0000_0020, "R5 code syscall");
        eret = 1'b1; csr_sel = 2'd0; csr_wdata = 32'h0; csr_wr = 1'b1;
        tick();
        rd(2'd0, v); chk(v, 32'h0000_FF3F, "R10 return beats status write");
        chk(redirect_pc, 32'hFFFF_FFFC, "R3 return target");
        exc_req = 1'b1; eret = 1'b1; exc_code = 4'd10; exc_pc = 32'h0000_2000;
        csr_sel = 2'd2; csr_wdata = 32'h0000_0055; csr_wr = 1'b1;
        tick();
        chk(redirect_pc, 32'h8000_0080, "R10 exception beats return");
        rd(2'd2, v); chk(v, 32'h0000_1FFC, "R10 epc write dropped");
        rd(2'd0, v); chk(v, 32'h0000_FF3C, "R10 push not pop");
        rd(2'd1, v); chk(v, 32'h0000_0028, "R5 code reserved instruction");
    endtask

    initial begin
        rst = 1'b1; exc_req = 1'b0; exc_code = 4'd0; exc_pc = 32'h0;
        hw_irq = 5'b0; eret = 1'b0; csr_wr = 1'b0; csr_sel = 2'd0; csr_wdata = 32'h0;
        @(negedge clk);
        t_reset();
        t_exception();
        t_return();
        t_pending();
        t_software();
        t_priority();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(20000 * 5);
        checks++;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule